// File: doc/BRIEF.md
# Polynomial Product Convolution Array

This block multiplies two polynomials of a fixed order P and returns the 2P+1 coefficients of their product. Both operands are written one coefficient at a time into two coefficient banks. A pulse on `start` freezes the operands and starts a run. During the run a chain of P+1 multiply-add cells moves across the first operand and writes one product coefficient into the result bank on every clock. The block serves as the step inside an interpolation engine that builds a product of linear factors. Each run multiplies the polynomial built so far by one more factor.

Coefficients are 32-bit two's-complement fixed-point words. Every product and every sum keeps only its low 32 bits, so overflow wraps. Loading uses a valid/ready stream. The block deasserts `ld_ready` for the whole run and in the cycle a start is accepted, and a held `ld_valid` simply waits. The results leave on a second valid/ready stream in ascending coefficient order. Holding `rd_ready` low stalls that stream, and the word on offer stays unchanged until it is taken. `start` and `done` are plain level controls.

Top module: `poly_conv_array`

## Requirements
- R1: After reset `done` and `rd_valid` are 0 and `ld_ready` is 1.
- R2: A load transfer is a cycle with `ld_valid` and `ld_ready` both high. `ld_sel` = 0 writes the first operand A and `ld_sel` = 1 writes the second operand B. Each operand has its own write index, which starts at coefficient 0 (the constant term), goes up by one per transfer and returns to 0 after coefficient P. An accepted start sets both write indexes back to 0.
- R3: Result coefficient k, for k from 0 to 2P, equals the sum of A[i]·B[k−i] over every i where both indexes lie in 0..P.
- R4: Every product and every sum is taken modulo 2^32, so overflow wraps.
- R5: A start is accepted while the block is idle. `done` drops on the next edge and rises on the 2P+1-th rising edge after the accepting edge.
- R6: `ld_ready` is 0 while a run is active. Load attempts made during a run leave both operand banks unchanged.
- R7: A `start` pulse during a run is ignored. It does not change when `done` rises or the result it produces.
- R8: While `done` is high, the result stream offers C[0] through C[2P] in order and advances on each cycle with `rd_valid` and `rd_ready` both high. While `rd_ready` is low, `rd_data` and `rd_valid` hold. After the last transfer `rd_valid` stays 0 until another run completes.
- R9: The result bank and `done` keep their values until the next accepted start, even if new operand loads arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Operand coefficient offered |
| ld_ready | output | 1 | Operand coefficient can be taken |
| ld_sel | input | 1 | 0 selects operand A, 1 selects operand B |
| ld_data | input | 32 | Operand coefficient word |
| start | input | 1 | Begin a multiplication when idle |
| done | output | 1 | Result bank holds a complete product |
| rd_valid | output | 1 | Result coefficient offered |
| rd_ready | input | 1 | Result coefficient taken |
| rd_data | output | 32 | Result coefficient word |

## Verification
A window that slides wrongly or misses its zero padding gives wrong edge coefficients C[0] and C[2P]. Wrong padding also puts nonzero terms in products that must have zeros, so the first or last word read back is wrong. A miscounting run counter moves the rise of `done` away from exactly 2P+1 edges, and the bench sees that in the cycle it happens. A write index that fails to wrap or rewind places coefficients in the wrong slots, which shows as a shifted product on the very next run. A read pointer that skips or slips under stall shows at once as a repeated or missing word in the output stream.

// File: rtl/polyconv_pkg.sv
package polyconv_pkg;

  typedef enum logic {
    SEL_A = 1'b0,
    SEL_B = 1'b1
  } opsel_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;

endpackage

// File: rtl/pc_coef_bank.sv
module pc_coef_bank #(
  parameter int N = 5,
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  output logic [N-1:0][W-1:0] coefs
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  logic [PW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      coefs <= '0;
    end else if (clear) begin
      ptr <= '0;
    end else if (wr_en) begin
      coefs[ptr] <= wr_data;
      ptr        <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  // R6: contents only change on an accepted write
  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(coefs));

  // R2: rewind lands at index zero
  assert_rewind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ptr == '0));

endmodule

// File: rtl/pc_window.sv
module pc_window #(
  parameter int P = 4,
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                shift,
  input  logic [P:0][W-1:0]   a_coefs,
  output logic [P:0][W-1:0]   win
);
  localparam int L = 3 * P + 1;

  logic [L-1:0][W-1:0] pad;
  logic [L-1:0][W-1:0] pad_init;

  always_comb begin
    pad_init = '0;
    for (int m = 0; m <= P; m++) begin
      pad_init[P + m] = a_coefs[m];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad <= '0;
    end else if (load) begin
      pad <= pad_init;
    end else if (shift) begin
      for (int m = 0; m < L - 1; m++) begin
        pad[m] <= pad[m + 1];
      end
      pad[L-1] <= '0;
    end
  end

  for (genvar j = 0; j <= P; j++) begin : g_tap
    assign win[j] = pad[j];
  end

  // R3: the trailing padding stays zero while sliding
  assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (pad[L-1] == '0));

endmodule

// File: rtl/pc_mac_cell.sv
module pc_mac_cell #(
  parameter int W = 32
) (
  input  logic [W-1:0] sum_in,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum_out
);
  logic [W-1:0] prod;

  always_comb begin
    prod    = a * b;
    sum_out = sum_in + prod;
  end

endmodule

// File: rtl/pc_mac_chain.sv
module pc_mac_chain #(
  parameter int P = 4,
  parameter int W = 32
) (
  input  logic [P:0][W-1:0] win,
  input  logic [P:0][W-1:0] b_coefs,
  output logic [W-1:0]      sum
);
  logic [P+1:0][W-1:0] psum;

  assign psum[0] = '0;

  for (genvar n = 0; n <= P; n++) begin : g_cell
    pc_mac_cell #(.W(W)) u_cell (
      .sum_in (psum[n]),
      .a      (win[P - n]),
      .b      (b_coefs[n]),
      .sum_out(psum[n + 1])
    );
  end

  assign sum = psum[P + 1];

endmodule

// File: rtl/pc_result_bank.sv
module pc_result_bank #(
  parameter int N = 9,
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_addr,
  input  logic [W-1:0]         wr_data,
  input  logic                 rd_rewind,
  input  logic                 rd_enable,
  input  logic                 rd_ready,
  output logic                 rd_valid,
  output logic [W-1:0]         rd_data
);
  localparam int AW = $clog2(N);
  localparam int RW = $clog2(N + 1);
  localparam logic [RW-1:0] END_PTR = RW'(N);

  logic [N-1:0][W-1:0] mem;
  logic [RW-1:0]       rptr;
  logic [AW-1:0]       ridx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
    end else if (rd_rewind) begin
      rptr <= '0;
    end else if (rd_valid && rd_ready) begin
      rptr <= rptr + 1'b1;
    end
  end

  assign ridx     = rptr[AW-1:0];
  assign rd_valid = rd_enable && (rptr < END_PTR);
  assign rd_data  = (rptr < END_PTR) ? mem[ridx] : '0;

  // R8: a stalled word holds
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !rd_rewind && !wr_en) |=> (rd_valid && $stable(rd_data)));

  // R8: nothing is offered while the bank is being written
  assert_no_rd_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_valid);

  // R9: the bank holds when no run writes it
  assert_bank_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem));

endmodule

// File: rtl/poly_conv_array.sv
module poly_conv_array #(
  parameter int ORDER = 4,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic             ld_sel,
  input  logic [WIDTH-1:0] ld_data,
  input  logic             start,
  output logic             done,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data
);
  import polyconv_pkg::*;

  localparam int NC = ORDER + 1;
  localparam int NR = 2 * ORDER + 1;
  localparam int KW = $clog2(NR);
  localparam logic [KW-1:0] K_LAST = KW'(NR - 1);

  run_state_t state;
  logic [KW-1:0] k;
  logic go;
  logic a_wr, b_wr;
  logic [NC-1:0][WIDTH-1:0] a_coefs, b_coefs;
  logic [ORDER:0][WIDTH-1:0] win;
  logic [WIDTH-1:0] mac_sum;
  logic c_wr;

  assign go       = start && (state == ST_IDLE);
  assign ld_ready = (state == ST_IDLE) && !start;
  assign a_wr     = ld_valid && ld_ready && (opsel_t'(ld_sel) == SEL_A);
  assign b_wr     = ld_valid && ld_ready && (opsel_t'(ld_sel) == SEL_B);
  assign c_wr     = (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      k     <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (go) begin
            state <= ST_RUN;
            k     <= '0;
            done  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (k == K_LAST) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            k     <= '0;
          end else begin
            k <= k + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  pc_coef_bank #(.N(NC), .W(WIDTH)) u_bank_a (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (go),
    .wr_en  (a_wr),
    .wr_data(ld_data),
    .coefs  (a_coefs)
  );

  pc_coef_bank #(.N(NC), .W(WIDTH)) u_bank_b (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (go),
    .wr_en  (b_wr),
    .wr_data(ld_data),
    .coefs  (b_coefs)
  );

  pc_window #(.P(ORDER), .W(WIDTH)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (go),
    .shift  (c_wr),
    .a_coefs(a_coefs),
    .win    (win)
  );

  pc_mac_chain #(.P(ORDER), .W(WIDTH)) u_chain (
    .win    (win),
    .b_coefs(b_coefs),
    .sum    (mac_sum)
  );

  pc_result_bank #(.N(NR), .W(WIDTH)) u_bank_c (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (c_wr),
    .wr_addr  (k),
    .wr_data  (mac_sum),
    .rd_rewind(go),
    .rd_enable(done),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // R5: the final step raises done
  assert_done_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && k == K_LAST) |=> done);

  // R5: an accepted start clears done
  assert_done_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !done);

  // R7: a run is never cut short
  assert_run_continues_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && k != K_LAST) |=> (state == ST_RUN && k == $past(k) + 1'b1));

  // R6: no operand write during a run
  assert_no_load_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> !(a_wr || b_wr));

endmodule

// File: tb/poly_conv_array_tb.sv
module poly_conv_array_tb;
  localparam int P  = 4;
  localparam int NC = P + 1;
  localparam int NR = 2 * P + 1;
  localparam int NV = 3;

  localparam logic [31:0] TAB_A [NV][NC] = '{
    '{32'd1, 32'd2, 32'd3, 32'd4, 32'd5},
    '{32'hFFFFFFFF, 32'd0, 32'd2, 32'hFFFFFFFD, 32'd1},
    '{32'h7FFFFFFF, 32'h80000000, 32'd3, 32'd0, 32'hFFFFFFFF}
  };
  localparam logic [31:0] TAB_B [NV][NC] = '{
    '{32'd1, 32'd1, 32'd1, 32'd1, 32'd1},
    '{32'd2, 32'hFFFFFFFF, 32'd0, 32'd0, 32'd4},
    '{32'd2, 32'd3, 32'h00010000, 32'd1, 32'h7FFFFFFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic ld_ready;
  logic ld_sel = 1'b0;
  logic [31:0] ld_data = '0;
  logic start = 1'b0;
  logic done;
  logic rd_valid;
  logic rd_ready = 1'b0;
  logic [31:0] rd_data;

  int checks = 0;
  int fails = 0;
  logic [31:0] cur_a [NC];
  logic [31:0] cur_b [NC];
  logic [31:0] exp_c [NR];

  always #5 clk = ~clk;

  poly_conv_array #(.ORDER(P), .WIDTH(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_sel(ld_sel), .ld_data(ld_data), .start(start), .done(done),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic compute_expect();
    for (int k = 0; k < NR; k++) begin
      logic [31:0] acc;
      acc = '0;
      for (int i = 0; i < NC; i++) begin
        if (k - i >= 0 && k - i < NC) acc = acc + cur_a[i] * cur_b[k - i];
      end
      exp_c[k] = acc;
    end
  endtask

  task automatic load_one(input logic sel, input logic [31:0] val);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_sel   = sel;
    ld_data  = val;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic load_operands();
    for (int i = 0; i < NC; i++) load_one(1'b0, cur_a[i]);
    for (int i = 0; i < NC; i++) load_one(1'b1, cur_b[i]);
  endtask

  // start, then check done each cycle; optionally poke start / loads mid-run
  task automatic run_timed(input bit poke_start, input bit poke_load);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R5 done low after start", {31'd0, done}, 32'd0);
    for (int n = 1; n <= NR; n++) begin
      if (poke_load) begin
        ld_valid = 1'b1;
        ld_sel   = n[0];
        ld_data  = 32'hDEAD0000 + n;
      end
      if (poke_start) start = (n == 3);
      @(negedge clk);
      if (poke_load) chk("R6 ld_ready low in run", {31'd0, ld_ready}, (n == NR) ? 32'd1 : 32'd0);
      chk(poke_start ? "R7 done timing with extra start" : "R5 done timing",
          {31'd0, done}, (n == NR) ? 32'd1 : 32'd0);
    end
    start    = 1'b0;
    ld_valid = 1'b0;
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < NR; i++) begin
      chk({req, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
      chk(req, rd_data, exp_c[i]);
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
    end
    chk("R8 rd_valid low after last", {31'd0, rd_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R1 ld_ready", {31'd0, ld_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ld_ready after release", {31'd0, ld_ready}, 32'd1);

    // table of vectors: R3 general, R4 wrap (last entry)
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < NC; i++) begin
        cur_a[i] = TAB_A[v][i];
        cur_b[i] = TAB_B[v][i];
      end
      compute_expect();
      load_operands();
      run_timed(1'b0, 1'b0);
      if (v == 0) begin
        // R8 stall: word holds while rd_ready low
        for (int s = 0; s < 3; s++) begin
          chk("R8 stall valid", {31'd0, rd_valid}, 32'd1);
          chk("R8 stall data", rd_data, exp_c[0]);
          @(negedge clk);
        end
      end
      read_all((v == NV - 1) ? "R4 wrapped coefficient" : "R3 product coefficient");
    end

    // R2: six writes to A wrap the index, last lands in slot 0
    for (int i = 0; i < NC; i++) load_one(1'b0, 32'd100 + i);
    load_one(1'b0, 32'd77);
    cur_a[0] = 32'd77;
    for (int i = 1; i < NC; i++) cur_a[i] = 32'd100 + i;
    for (int i = 0; i < NC; i++) begin
      cur_b[i] = (i == 0) ? 32'd1 : 32'd0;
      load_one(1'b1, cur_b[i]);
    end
    compute_expect();
    run_timed(1'b0, 1'b0);
    read_all("R2 load index wrap");

    // R2: start rewinds write index (A ptr was left at 1): reload from 0
    cur_a[0] = 32'd3; cur_a[1] = 32'd0; cur_a[2] = 32'd0; cur_a[3] = 32'd0; cur_a[4] = 32'd9;
    for (int i = 0; i < NC; i++) load_one(1'b0, cur_a[i]);
    compute_expect();
    run_timed(1'b0, 1'b0);
    read_all("R2 rewind on start");

    // R6: loads attempted during a run are ignored; rerun gives same result
    run_timed(1'b0, 1'b1);
    read_all("R6 banks unchanged by run-time loads");

    // R7: start during run ignored; result still correct
    run_timed(1'b1, 1'b0);
    read_all("R7 result with extra start");

    // R9: new loads after done leave C and done intact; reread via new run is not needed
    for (int i = 0; i < NC; i++) load_one(1'b0, 32'h55550000 + i);
    chk("R9 done held", {31'd0, done}, 32'd1);
    chk("R9 rd_valid stays low after drain", {31'd0, rd_valid}, 32'd0);
    // run once more with B still unit: C equals new A, confirms load took effect only now
    for (int i = 0; i < NC; i++) cur_a[i] = 32'h55550000 + i;
    compute_expect();
    run_timed(1'b0, 1'b0);
    // load fresh operands before reading: C must still be the previous product
    for (int i = 0; i < NC; i++) load_one(1'b1, 32'd2);
    chk("R9 done held across loads", {31'd0, done}, 32'd1);
    read_all("R9 result bank kept");

    summary();
    $finish;
  end

endmodule